// File: doc/BRIEF.md
# Processor Bus Bridge with Address Decode and Clock Stall

This block sits between a pipelined processor core and two slaves: an instruction memory and a serial port peripheral. It owns the processor's two-phase, non-overlapping clock, which it generates from the system clock with a four-step sequence: phase one high, both low, phase two high, both low. In the gap after phase one it samples the processor's request and decodes the address. It then starts a strobe/acknowledge transfer toward the matching slave. An access to an address that no slave decodes completes at once with zero read data.

The processor does not need to see wait states. While a transfer is waiting for its acknowledge, or while the peripheral interrupt line is high, the bridge parks its phase sequence in the gap after phase two. Both phases then stay low and the core is frozen. The sequence resumes with phase one once nothing holds it. All state uses a synchronous, active-high reset. Inputs are sampled on the rising edge of `clk`, and every output comes from a register clocked on that same edge.

Top module: `cpu_bus_bridge`

## Requirements
- R1: A request whose address has every bit above bit 15 at zero and `cpu_we` low starts a memory transfer. `mem_addr` carries address bits 15:0. The word returned with `mem_ack` appears on `cpu_rdata`.
- R2: A read (`cpu_we` low) at address 0x0010001 raises `ssp_stb` with `ssp_we` low. The byte on `ssp_rdata` at acknowledge is returned zero-extended on `cpu_rdata`.
- R3: A write (`cpu_we` high) at address 0x0010000 raises `ssp_stb` with `ssp_we` high and `ssp_wdata` equal to `cpu_wdata`. On completion `cpu_rdata` reads zero.
- R4: Any other request completes without any strobe and sets `cpu_rdata` to zero. This includes writes into the memory range, a write at 0x0010001 and a read at 0x0010000. Such a request adds no stall.
- R5: A strobe stays high until its acknowledge is sampled and is low in the following cycle. At most one strobe is high at a time.
- R6: `cpu_phi1` and `cpu_phi2` are never high together. The cycle after either phase is high has the other phase low.
- R7: For a mapped access acknowledged L cycles after its strobe rises, phase one returns L+4 cycles after the cycle in which phase one was high when the request was taken. An access with no stall returns after 4 cycles, and phase one stays low while a strobe is high.
- R8: With `irq` held for H cycles from a phase-one cycle and no request, phase one returns after max(H+1, 4) cycles. Both phases stay low while held, and `cpu_rdata` is unchanged.
- R9: During reset both phases, both strobes, `ssp_we` and `cpu_rdata` are zero.
- R10: When an interrupt of H cycles and a mapped access of latency L start together, phase one returns after max(H+1, L+4) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | 28 | Processor address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 32 | Data returned to the processor |
| cpu_phi1 | output | 1 | Processor clock phase one |
| cpu_phi2 | output | 1 | Processor clock phase two |
| irq | input | 1 | Peripheral interrupt, holds the processor clocks |
| mem_stb | output | 1 | Instruction memory strobe |
| mem_addr | output | 16 | Instruction memory word address |
| mem_ack | input | 1 | Instruction memory acknowledge |
| mem_rdata | input | 32 | Instruction word from memory |
| ssp_stb | output | 1 | Serial port strobe |
| ssp_we | output | 1 | Serial port direction, 1 write |
| ssp_wdata | output | 8 | Byte sent to the serial port |
| ssp_ack | input | 1 | Serial port acknowledge |
| ssp_rdata | input | 8 | Byte received from the serial port |

## Verification
The interrupt hold and the wait for a slave acknowledge can both stall the clock in the same cycle, and both act through the one parking point in the phase sequence. The bench raises `irq` in the same cycle it presents a mapped request. It sweeps the interrupt length against the slave latency, so either cause can end the stall last. It judges each run by counting cycles until phase one returns and comparing the count with max(H+1, L+4). Throughout, it watches that neither phase pulses and that no extra strobe appears.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_MEM    = 2'd1,
    TGT_SSP_RD = 2'd2,
    TGT_SSP_WR = 2'd3
  } bbr_tgt_e;

  localparam logic [1:0] PH_P1    = 2'd0;
  localparam logic [1:0] PH_GAP_A = 2'd1;
  localparam logic [1:0] PH_P2    = 2'd2;
  localparam logic [1:0] PH_GAP_B = 2'd3;

  // Phase step: parks in the second gap while held, else wraps around.
  function automatic logic [1:0] bbr_next_phase(input logic [1:0] ph, input logic hold);
    if (ph == PH_GAP_B && hold) return ph;
    return ph + 2'd1;
  endfunction
endpackage

// File: rtl/bbr_phase_gen.sv
module bbr_phase_gen
  import bbr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic phi1,
  output logic phi2,
  output logic capture_slot,
  output logic hold_now
);
  logic [1:0] ph;
  logic [1:0] ph_nxt;

  assign ph_nxt       = bbr_next_phase(ph, hold);
  assign capture_slot = (ph == PH_GAP_A);
  assign hold_now     = (ph == PH_GAP_B) && hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_GAP_B;
      phi1 <= 1'b0;
      phi2 <= 1'b0;
    end else begin
      ph   <= ph_nxt;
      phi1 <= (ph_nxt == PH_P1);
      phi2 <= (ph_nxt == PH_P2);
    end
  end
endmodule

// File: rtl/bbr_addr_decode.sv
module bbr_addr_decode
  import bbr_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int MEM_AW = 16,
  parameter logic [ADDR_W-1:0] SSP_WR_ADDR = 28'h0010000,
  parameter logic [ADDR_W-1:0] SSP_RD_ADDR = 28'h0010001
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output bbr_tgt_e          tgt
);
  localparam int HI_W = ADDR_W - MEM_AW;

  logic in_mem;
  assign in_mem = (addr[ADDR_W-1:MEM_AW] == {HI_W{1'b0}});

  always_comb begin
    if (in_mem && !we)                   tgt = TGT_MEM;
    else if (!we && addr == SSP_RD_ADDR) tgt = TGT_SSP_RD;
    else if (we && addr == SSP_WR_ADDR)  tgt = TGT_SSP_WR;
    else                                 tgt = TGT_NONE;
  end
endmodule

// File: rtl/bbr_xfer_ctrl.sv
module bbr_xfer_ctrl
  import bbr_pkg::*;
#(
  parameter int MEM_AW = 16,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  bbr_tgt_e          tgt,
  input  logic [MEM_AW-1:0] addr_lo,
  input  logic [BYTE_W-1:0] wdata,
  output logic              busy,
  output logic              mem_stb,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ssp_stb,
  output logic              ssp_we,
  output logic [BYTE_W-1:0] ssp_wdata,
  input  logic              ssp_ack,
  input  logic [BYTE_W-1:0] ssp_rdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - BYTE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      mem_stb   <= 1'b0;
      mem_addr  <= '0;
      ssp_stb   <= 1'b0;
      ssp_we    <= 1'b0;
      ssp_wdata <= '0;
      rdata     <= '0;
    end else if (start && !busy) begin
      unique case (tgt)
        TGT_MEM: begin
          busy     <= 1'b1;
          mem_stb  <= 1'b1;
          mem_addr <= addr_lo;
        end
        TGT_SSP_RD: begin
          busy    <= 1'b1;
          ssp_stb <= 1'b1;
          ssp_we  <= 1'b0;
        end
        TGT_SSP_WR: begin
          busy      <= 1'b1;
          ssp_stb   <= 1'b1;
          ssp_we    <= 1'b1;
          ssp_wdata <= wdata;
        end
        default: rdata <= '0;
      endcase
    end else if (mem_stb && mem_ack) begin
      mem_stb <= 1'b0;
      busy    <= 1'b0;
      rdata   <= mem_rdata;
    end else if (ssp_stb && ssp_ack) begin
      ssp_stb <= 1'b0;
      busy    <= 1'b0;
      ssp_we  <= 1'b0;
      rdata   <= ssp_we ? '0 : {{PAD_W{1'b0}}, ssp_rdata};
    end
  end
endmodule

// File: rtl/cpu_bus_bridge.sv
module cpu_bus_bridge
  import bbr_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int MEM_AW = 16,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] SSP_WR_ADDR = 28'h0010000,
  parameter logic [ADDR_W-1:0] SSP_RD_ADDR = 28'h0010001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_phi1,
  output logic              cpu_phi2,
  input  logic              irq,
  output logic              mem_stb,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ssp_stb,
  output logic              ssp_we,
  output logic [BYTE_W-1:0] ssp_wdata,
  input  logic              ssp_ack,
  input  logic [BYTE_W-1:0] ssp_rdata
);
  bbr_tgt_e tgt;
  logic     busy;
  logic     hold;
  logic     capture_slot;
  logic     hold_now;
  logic     xfer_start;
  logic     start_unmapped;

  assign hold           = irq | busy;
  assign xfer_start     = capture_slot & cpu_req & ~busy;
  assign start_unmapped = xfer_start && (tgt == TGT_NONE);

  bbr_phase_gen u_phase (
    .clk(clk), .rst(rst), .hold(hold),
    .phi1(cpu_phi1), .phi2(cpu_phi2),
    .capture_slot(capture_slot), .hold_now(hold_now)
  );

  bbr_addr_decode #(
    .ADDR_W(ADDR_W), .MEM_AW(MEM_AW),
    .SSP_WR_ADDR(SSP_WR_ADDR), .SSP_RD_ADDR(SSP_RD_ADDR)
  ) u_dec (
    .addr(cpu_addr), .we(cpu_we), .tgt(tgt)
  );

  bbr_xfer_ctrl #(
    .MEM_AW(MEM_AW), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
  ) u_xfer (
    .clk(clk), .rst(rst), .start(xfer_start), .tgt(tgt),
    .addr_lo(cpu_addr[MEM_AW-1:0]), .wdata(cpu_wdata), .busy(busy),
    .mem_stb(mem_stb), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ssp_stb(ssp_stb), .ssp_we(ssp_we), .ssp_wdata(ssp_wdata),
    .ssp_ack(ssp_ack), .ssp_rdata(ssp_rdata), .rdata(cpu_rdata)
  );
endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              phi1,
  input logic              phi2,
  input logic              mem_stb,
  input logic              mem_ack,
  input logic              ssp_stb,
  input logic              ssp_ack,
  input logic              ssp_we,
  input logic [DATA_W-1:0] rdata,
  input logic              hold_now,
  input logic              start_unmapped
);
  AST_PHASE_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(phi1 && phi2)); // R6
  AST_PHASE_GAP_AFTER_P1: assert property (@(posedge clk) disable iff (rst) $past(phi1) |-> !phi2); // R6
  AST_PHASE_GAP_AFTER_P2: assert property (@(posedge clk) disable iff (rst) $past(phi2) |-> !phi1); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) !(mem_stb && ssp_stb)); // R5
  AST_MEM_STB_HELD: assert property (@(posedge clk) disable iff (rst) mem_stb && !mem_ack |=> mem_stb); // R5
  AST_MEM_STB_DROP: assert property (@(posedge clk) disable iff (rst) mem_stb && mem_ack |=> !mem_stb); // R5
  AST_SSP_STB_HELD: assert property (@(posedge clk) disable iff (rst) ssp_stb && !ssp_ack |=> ssp_stb); // R5
  AST_SSP_STB_DROP: assert property (@(posedge clk) disable iff (rst) ssp_stb && ssp_ack |=> !ssp_stb); // R5
  AST_NO_P1_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst) (mem_stb || ssp_stb) |-> !phi1); // R7
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst) hold_now |=> !phi1 && !phi2); // R8
  AST_UNMAPPED_NO_STB: assert property (@(posedge clk) disable iff (rst) start_unmapped |=> !mem_stb && !ssp_stb && rdata == '0); // R4
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !phi1 && !phi2 && !mem_stb && !ssp_stb && !ssp_we); // R9
endmodule

bind cpu_bus_bridge bbr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .phi1(cpu_phi1), .phi2(cpu_phi2),
  .mem_stb(mem_stb), .mem_ack(mem_ack), .ssp_stb(ssp_stb), .ssp_ack(ssp_ack),
  .ssp_we(ssp_we), .rdata(cpu_rdata), .hold_now(hold_now), .start_unmapped(start_unmapped)
);

// File: tb/cpu_bus_bridge_bench.sv
`timescale 1ns/1ps
module cpu_bus_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [27:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_phi1, cpu_phi2;
  logic        irq = 1'b0;
  logic        mem_stb;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata;
  logic        ssp_stb, ssp_we;
  logic [7:0]  ssp_wdata;
  logic        ssp_ack = 1'b0;
  logic [7:0]  ssp_rdata = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lat = 0, mcnt = 0, scnt = 0;
  int mem_rises = 0, ssp_rises = 0, overlaps = 0;
  logic prev_mstb = 1'b0, prev_sstb = 1'b0;
  logic [15:0] cap_maddr = '0;
  logic [7:0]  cap_wd = '0;
  logic        cap_we = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  // Memory model: word is address concatenated with its inverse (R1)
  assign mem_rdata = {mem_addr, ~mem_addr};

  cpu_bus_bridge u_cpu_bus_bridge (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_phi1(cpu_phi1), .cpu_phi2(cpu_phi2),
    .irq(irq), .mem_stb(mem_stb), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ssp_stb(ssp_stb), .ssp_we(ssp_we), .ssp_wdata(ssp_wdata),
    .ssp_ack(ssp_ack), .ssp_rdata(ssp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Slave responders and monitors, all on the falling edge
  always @(negedge clk) begin
    if (mem_stb) begin
      if (mcnt == lat) begin mem_ack = 1'b1; cap_maddr = mem_addr; end
      mcnt++;
    end else begin mem_ack = 1'b0; mcnt = 0; end
    if (ssp_stb) begin
      if (scnt == lat) begin ssp_ack = 1'b1; cap_wd = ssp_wdata; cap_we = ssp_we; end
      scnt++;
    end else begin ssp_ack = 1'b0; scnt = 0; end
    if (!rst) begin
      if (cpu_phi1 && cpu_phi2) overlaps++;
      if (mem_stb && !prev_mstb) mem_rises++;
      if (ssp_stb && !prev_sstb) ssp_rises++;
    end
    prev_mstb = mem_stb;
    prev_sstb = ssp_stb;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // kind: 0 none/unmapped, 1 mem, 2 ssp read, 3 ssp write
  task automatic run(input bit do_req, input logic [27:0] a, input bit we, input logic [7:0] wd,
                     input int l, input int irqh, input int kind, input logic [31:0] exp_rd,
                     input string tag);
    int n;
    int exp_n;
    int mr0, sr0, ov0;
    lat = l;
    do @(negedge clk); while (!cpu_phi1);
    mr0 = mem_rises; sr0 = ssp_rises; ov0 = overlaps;
    cpu_req = do_req; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
    if (irqh > 0) irq = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (cpu_phi2) cpu_req = 1'b0;
      if (n == irqh) irq = 1'b0;
    end while (!cpu_phi1);
    exp_n = (kind != 0) ? l + 4 : 4;
    if (irqh > 0) exp_n = imax(irqh + 1, exp_n);
    chk(n == exp_n, {tag, " resume cycles"}, n, exp_n);
    chk(cpu_rdata == exp_rd, {tag, " rdata"}, cpu_rdata, exp_rd);
    chk(mem_rises - mr0 == int'(kind == 1), {tag, " R5 mem strobes"}, mem_rises - mr0, kind == 1);
    chk(ssp_rises - sr0 == int'(kind >= 2), {tag, " R5 ssp strobes"}, ssp_rises - sr0, kind >= 2);
    chk(overlaps == ov0, {tag, " R6 overlap"}, overlaps - ov0, 0);
    if (kind == 1) chk(cap_maddr == a[15:0], {tag, " R1 mem_addr"}, cap_maddr, a[15:0]);
    if (kind == 2) chk(cap_we == 1'b0, {tag, " R2 ssp_we"}, cap_we, 0);
    if (kind == 3) chk(cap_we == 1'b1 && cap_wd == wd, {tag, " R3 ssp write"}, {cap_we, cap_wd}, {1'b1, wd});
  endtask

  initial begin
    logic [27:0] maddrs [6];
    logic [7:0]  bytes [4];
    maddrs = '{28'h0000000, 28'h000FFFF, 28'h0001234, 28'h0008000, 28'h00055AA, 28'h0000001};
    bytes  = '{8'h00, 8'hA5, 8'hFF, 8'h3C};
    repeat (4) @(negedge clk);
    chk(!cpu_phi1 && !cpu_phi2, "R9 phases in reset", {cpu_phi1, cpu_phi2}, 0);
    chk(!mem_stb && !ssp_stb && !ssp_we, "R9 strobes in reset", {mem_stb, ssp_stb, ssp_we}, 0);
    chk(cpu_rdata == 0, "R9 rdata in reset", cpu_rdata, 0);
    rst = 1'b0;

    for (int i = 0; i < 6; i++)
      for (int l = 0; l < 4; l++)
        run(1, maddrs[i], 0, 8'h00, l, 0, 1, {maddrs[i][15:0], ~maddrs[i][15:0]}, "R1 R7 mem fetch");

    for (int i = 0; i < 4; i++) begin
      ssp_rdata = bytes[i];
      run(1, 28'h0010001, 0, 8'h00, i, 0, 2, {24'h0, bytes[i]}, "R2 ssp read");
      run(1, 28'h0010000, 1, ~bytes[i], 3 - i, 0, 3, 32'h0, "R3 ssp write");
      run(1, 28'h0000ABC, 0, 8'h00, 0, 0, 1, {16'h0ABC, ~16'h0ABC}, "R1 refill");
      run(1, 28'h0010002 + 28'(i), 0, 8'h00, 2, 0, 0, 32'h0, "R4 unmapped read");
    end
    run(1, 28'h0000ABC, 0, 8'h00, 0, 0, 1, {16'h0ABC, ~16'h0ABC}, "R1 refill");
    run(1, 28'h0000010, 1, 8'h77, 1, 0, 0, 32'h0, "R4 write to memory range");
    run(1, 28'h0000ABC, 0, 8'h00, 0, 0, 1, {16'h0ABC, ~16'h0ABC}, "R1 refill");
    run(1, 28'h0010001, 1, 8'h11, 1, 0, 0, 32'h0, "R4 write at read address");
    ssp_rdata = 8'h5A;
    run(1, 28'h0010001, 0, 8'h00, 1, 0, 2, 32'h5A, "R2 refill");
    run(1, 28'h0010000, 0, 8'h00, 1, 0, 0, 32'h0, "R4 read at write address");
    run(1, 28'hFFFFFFF, 0, 8'h00, 1, 0, 0, 32'h0, "R4 top address");

    run(1, 28'h0000042, 0, 8'h00, 0, 0, 1, {16'h0042, ~16'h0042}, "R1 refill");
    for (int h = 1; h < 9; h++)
      run(0, 28'h0, 0, 8'h00, 0, h, 0, {16'h0042, ~16'h0042}, "R8 irq hold");

    for (int h = 1; h < 11; h += 3)
      for (int l = 0; l < 6; l += 2)
        run(1, 28'h0000100 + 28'(h), 0, 8'h00, l, h, 1,
            {16'h0100 + 16'(h), ~(16'h0100 + 16'(h))}, "R10 irq with mem");
    ssp_rdata = 8'hC3;
    run(1, 28'h0010001, 0, 8'h00, 5, 3, 2, 32'hC3, "R10 irq with ssp read");
    run(1, 28'h0010000, 1, 8'h9E, 1, 8, 3, 32'h0, "R10 irq with ssp write");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule